// File: doc/BRIEF.md
# Conversion Handshake and Serial Result Port

This block sits between a converter core and a host microcontroller. The host starts a conversion by pulling its active-low chip-select line low. The block answers with a one-cycle start pulse to the core and captures the channel choice. It then uses its single serial data line as a status signal. The line is enabled and held low while the core works, and it goes high when the core reports a result. After that, each falling edge of the host's serial clock puts the next bit of the 15-bit result on the line, most significant bit first.

The chip-select and serial-clock inputs arrive from the host without any timing relation to the block clock. Each passes through a synchronizer with a parameterized number of stages before edge detection. The result strobe and word come from the core in the block's own clock domain. The data line is modelled as a value plus an output enable, and the enable low stands for high impedance. If chip select rises before the result is ready, the cycle is abandoned. Once the result is ready, the line stays driven until every bit has been placed and chip select is high.

Top module: `conv_serial_port`

## Requirements
- R1: After reset the data line enable `sdo_oe_o` is 0 (high impedance) and `conv_go_o` is 0.
- R2: A falling edge on `cs_n_i` while idle produces a `conv_go_o` pulse exactly one clock long. In that same cycle the line is enabled and driven low (busy).
- R3: `chan_i` is sampled when the cycle starts. `conv_ch_o` is 0 when the sampled level was low (channel 1) and 1 when it was high (channel 2). `conv_ch_o` keeps that value for the whole cycle even if `chan_i` changes.
- R4: A `res_vld_i` strobe during the busy phase captures `res_i` and drives the line high (ready).
- R5: The first falling edge of `sck_i` after ready places result bit 14 on the line. Each later falling edge places the next lower bit, down to bit 0.
- R6: Once ready, the line is released only after bit 0 has been placed and `cs_n_i` is high. A rise of `cs_n_i` earlier in the readout does not release the line or disturb the remaining bits.
- R7: A rise of `cs_n_i` during the busy phase aborts the cycle and releases the line. A later `res_vld_i` strobe has no effect, and the line stays released.
- R8: A `res_vld_i` strobe while idle is ignored. The line stays released, and the next cycle reads out the word captured during its own busy phase.
- R9: Falling edges of `sck_i` during the busy phase are ignored. The line stays low, and the readout still starts at bit 14.
- R10: Falling edges of `sck_i` after bit 0 has been placed drive the line low while `cs_n_i` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Host chip select / conversion start, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, idles high, asynchronous |
| chan_i | input | 1 | Channel select: low = channel 1, high = channel 2 |
| res_vld_i | input | 1 | One-cycle strobe from the core: result word valid |
| res_i | input | DATA_W (15) | Result word from the core |
| sdo_o | output | 1 | Serial data / status value |
| sdo_oe_o | output | 1 | Drive enable for the serial line (0 = high impedance) |
| conv_go_o | output | 1 | One-cycle conversion start pulse to the core |
| conv_ch_o | output | 1 | Latched channel for the core (0 = channel 1, 1 = channel 2) |

## Verification
The bench builds the block with its defaults: a 15-bit word and two synchronizer stages. With these values the output moves a fixed three clocks after a host pin changes. The bench therefore samples every bit in the exact cycle it appears, so a lost or doubled shift shows up as a wrong bit. The full word width exercises the index counter all the way from 14 down to 0. This brings the placement of the last bit and the release condition that depends on it within reach, along with the early and late chip-select cases.

// File: rtl/cssp_pkg.sv
package cssp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_READY,
        ST_SHIFT,
        ST_TAIL
    } cssp_state_e;

    typedef struct packed {
        cssp_state_e st;
        logic        go;
        logic        ch;
    } cssp_ctrl_t;

endpackage

// File: rtl/cssp_sync.sv
module cssp_sync #(
    parameter int   N       = 2,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);

    localparam int PW = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [PW-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[PW-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {PW{RST_VAL}};
            else        pipe_q <= pipe_d;
        end

        assign lvl[i]  = pipe_q[STAGES-1];
        assign prev[i] = pipe_q[STAGES];
    end

endmodule

// File: rtl/cssp_shift.sv
module cssp_shift #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         adv,
    output logic         bit_o,
    output logic         last_o
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [IW-1:0] idx;
    } shift_t;

    shift_t d, q;

    always_comb begin
        d = q;
        if (load) begin
            d.sr  = word;
            d.idx = IW'(W - 1);
        end else if (adv && q.idx != '0) begin
            d.sr  = {q.sr[W-2:0], 1'b0};
            d.idx = q.idx - IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o  = q.sr[W-1];
    assign last_o = (q.idx == '0);

    // R5: each accepted advance moves the bit index down by exactly one
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && q.idx != '0) |=> (q.idx == $past(q.idx) - IW'(1)));

endmodule

// File: rtl/cssp_ctrl.sv
module cssp_ctrl
    import cssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_high,
    input  logic sck_fall,
    input  logic chan,
    input  logic res_vld,
    input  logic last_bit,
    input  logic data_bit,
    output logic load,
    output logic adv,
    output logic line_oe,
    output logic line_val,
    output logic go,
    output logic ch
);

    cssp_ctrl_t d, q;

    always_comb begin
        d    = q;
        d.go = 1'b0;
        load = 1'b0;
        adv  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cs_fall) begin
                    d.st = ST_BUSY;
                    d.go = 1'b1;
                    d.ch = chan;
                end
            end
            ST_BUSY: begin
                if (cs_high) begin
                    d.st = ST_IDLE;
                end else if (res_vld) begin
                    d.st = ST_READY;
                    load = 1'b1;
                end
            end
            ST_READY: begin
                if (sck_fall) d.st = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (last_bit && cs_high) begin
                    d.st = ST_IDLE;
                end else if (sck_fall) begin
                    if (last_bit) d.st = ST_TAIL;
                    else          adv  = 1'b1;
                end
            end
            ST_TAIL: begin
                if (cs_high) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= ST_IDLE;
            q.go <= 1'b0;
            q.ch <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        line_oe  = (q.st != ST_IDLE);
        line_val = 1'b0;
        case (q.st)
            ST_READY: line_val = 1'b1;
            ST_SHIFT: line_val = data_bit;
            default:  line_val = 1'b0;
        endcase
    end

    assign go = q.go;
    assign ch = q.ch;

    // R2: the start pulse never lasts beyond one clock
    p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.go |=> !q.go);

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
    parameter int DATA_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              chan_i,
    input  logic              res_vld_i,
    input  logic [DATA_W-1:0] res_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              conv_go_o,
    output logic              conv_ch_o
);

    localparam int NSYNC = 2;
    localparam int CS_IX = 0;
    localparam int SK_IX = 1;

    logic [NSYNC-1:0] s_lvl, s_prev;
    logic cs_fall, cs_high, sck_fall;
    logic load, adv, last_bit, data_bit;

    cssp_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_i, cs_n_i}),
        .lvl  (s_lvl),
        .prev (s_prev)
    );

    assign cs_high  = s_lvl[CS_IX];
    assign cs_fall  = s_prev[CS_IX] & ~s_lvl[CS_IX];
    assign sck_fall = s_prev[SK_IX] & ~s_lvl[SK_IX];

    cssp_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .word  (res_i),
        .adv   (adv),
        .bit_o (data_bit),
        .last_o(last_bit)
    );

    cssp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_fall (cs_fall),
        .cs_high (cs_high),
        .sck_fall(sck_fall),
        .chan    (chan_i),
        .res_vld (res_vld_i),
        .last_bit(last_bit),
        .data_bit(data_bit),
        .load    (load),
        .adv     (adv),
        .line_oe (sdo_oe_o),
        .line_val(sdo_o),
        .go      (conv_go_o),
        .ch      (conv_ch_o)
    );

    // R2: the start pulse coincides with a driven-low busy line
    p_busy_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go_o |-> (sdo_oe_o && !sdo_o));

    // R3: the channel output holds while the line stays driven
    p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe_o && $past(sdo_oe_o)) |-> $stable(conv_ch_o));

    // R6: the line is only released with chip select seen high
    p_release_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sdo_oe_o) && !sdo_oe_o) |-> $past(cs_high));

endmodule

// File: tb/conv_serial_port_tb_top.sv
module conv_serial_port_tb_top;

    localparam int W = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b1;
    logic chan = 1'b0;
    logic res_vld = 1'b0;
    logic [W-1:0] res = '0;
    logic sdo, sdo_oe, conv_go, conv_ch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    conv_serial_port #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n),
        .sck_i    (sck),
        .chan_i   (chan),
        .res_vld_i(res_vld),
        .res_i    (res),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe),
        .conv_go_o(conv_go),
        .conv_ch_o(conv_ch)
    );

    // {chan, word}
    localparam logic [W:0] VEC [6] = '{
        {1'b0, 15'h7FFF}, {1'b1, 15'h0000}, {1'b0, 15'h5555},
        {1'b1, 15'h2AAA}, {1'b0, 15'h4001}, {1'b1, 15'h1234}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic begin_cycle(input string req, input logic ch);
        chan = ch;
        cs_n = 1'b0;
        wait_n(3);
        chk({req, " R2 go pulse"}, conv_go, 1);
        chk({req, " R2 busy low"}, {sdo_oe, sdo}, 2'b10);
        chk({req, " R3 channel"}, conv_ch, ch);
        wait_n(1);
        chk({req, " R2 go single"}, conv_go, 0);
    endtask

    task automatic deliver(input string req, input logic [W-1:0] w);
        res = w;
        res_vld = 1'b1;
        wait_n(1);
        res_vld = 1'b0;
        res = ~w;
        wait_n(2);
        chk({req, " R4 ready high"}, {sdo_oe, sdo}, 2'b11);
    endtask

    task automatic fall_chk(input string req, input logic [1:0] exp);
        sck = 1'b0;
        wait_n(3);
        chk(req, {sdo_oe, sdo}, exp);
        wait_n(1);
        sck = 1'b1;
        wait_n(4);
    endtask

    task automatic read_bits(input string req, input logic [W-1:0] w,
                             input int hi, input int lo);
        for (int b = hi; b >= lo; b--) begin
            fall_chk({req, " R5 bit"}, {1'b1, w[b]});
        end
    endtask

    task automatic end_cycle(input string req);
        cs_n = 1'b1;
        wait_n(4);
        chk({req, " R6 released"}, sdo_oe, 0);
    endtask

    initial begin
        wait_n(5);
        chk("R1 oe at reset", sdo_oe, 0);
        chk("R1 go at reset", conv_go, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk("R1 oe after reset", sdo_oe, 0);

        for (int v = 0; v < 6; v++) begin
            begin_cycle("vec", VEC[v][W]);
            deliver("vec", VEC[v][W-1:0]);
            read_bits("vec", VEC[v][W-1:0], W - 1, 0);
            end_cycle("vec");
        end

        // R3: channel change during the cycle
        begin_cycle("R3", 1'b1);
        chan = 1'b0;
        wait_n(4);
        chk("R3 channel held", conv_ch, 1);
        deliver("R3", 15'h0F0F);
        read_bits("R3", 15'h0F0F, W - 1, 0);
        chk("R3 channel held end", conv_ch, 1);
        end_cycle("R3");

        // R7: abort while busy, later strobe ignored
        begin_cycle("R7", 1'b1);
        cs_n = 1'b1;
        wait_n(4);
        chk("R7 abort released", sdo_oe, 0);
        res = 15'h7E7E;
        res_vld = 1'b1;
        wait_n(1);
        res_vld = 1'b0;
        wait_n(3);
        chk("R7 strobe ignored", sdo_oe, 0);

        // R8: strobe while idle ignored, next cycle uses its own word
        res = 15'h1234;
        res_vld = 1'b1;
        wait_n(1);
        res_vld = 1'b0;
        wait_n(3);
        chk("R8 idle strobe", sdo_oe, 0);
        begin_cycle("R8", 1'b0);
        deliver("R8", 15'h6C39);
        read_bits("R8", 15'h6C39, W - 1, 0);
        end_cycle("R8");

        // R9: serial clock edges while busy
        begin_cycle("R9", 1'b0);
        fall_chk("R9 busy sck ignored", 2'b10);
        fall_chk("R9 busy sck ignored", 2'b10);
        deliver("R9", 15'h4B2D);
        read_bits("R9", 15'h4B2D, W - 1, 0);
        end_cycle("R9");

        // R6: early chip-select rise during readout
        begin_cycle("R6", 1'b1);
        deliver("R6", 15'h3A5C);
        read_bits("R6", 15'h3A5C, W - 1, 10);
        cs_n = 1'b1;
        wait_n(4);
        chk("R6 early cs keeps drive", sdo_oe, 1);
        read_bits("R6", 15'h3A5C, 9, 0);
        wait_n(2);
        chk("R6 release after last bit", sdo_oe, 0);

        // R10: extra serial clock edges after the last bit
        begin_cycle("R10", 1'b0);
        deliver("R10", 15'h7FFF);
        read_bits("R10", 15'h7FFF, W - 1, 0);
        fall_chk("R10 tail low", 2'b10);
        fall_chk("R10 tail low", 2'b10);
        end_cycle("R10");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule